// File: doc/BRIEF.md
# Gather Top Switch Arbiter

This block is one root-level node of the gather network that carries results from an array of processing elements back to a shared on-chip buffer. Several of these nodes form a chain; each one merges up to three gather streams (the bypass links from the processing elements below it and the stream handed on by the neighbouring node in the chain) into a single ordered stream. A stream that does not exist at a given position in the chain has its valid input tied low.

In every cycle in which its output queue has room, the node grants one requesting input. It picks that input with rotating priority and writes the flit into a small output queue. The head of the queue is offered to the next node, or to the buffer port. It leaves only when that consumer grants it and is not signalling "off". Each input also receives an "off" level. This level rises as soon as the free space in the queue falls below a configurable reserve, so that upstream senders can stop injecting in time.

Top module: `gatherTopSwitch`

## Requirements
- R1: After reset the queue is empty: `outValid` is 0, no input is granted until one raises its valid, and every `inOff` bit is 0.
- R2: At most one `inGrant` bit is high in a cycle, only for an input whose `inValid` is high. When the queue is not full and at least one input is valid, exactly one input is granted.
- R3: Priority rotates. After reset, input 0 has first priority. After a grant to input k, the search starts at input k+1 (wrapping to 0) and takes the first valid input in ascending index order.
- R4: An input that keeps its valid high is granted after waiting at most two cycles in which some input was granted.
- R5: A granted flit (lane k occupies `inData[k*DATA_W +: DATA_W]`) is written into the queue on that clock edge. `outValid`/`outData` present the oldest queued flit, and flits leave in the order they were granted.
- R6: The head flit leaves on a clock edge only when `dnGrant` is 1 and `dnOff` is 0. Otherwise `outValid` stays 1 and `outData` does not change.
- R7: While the queue holds DEPTH flits, no input is granted, even in a cycle in which the head flit leaves.
- R8: All `inOff` bits are 1 exactly when DEPTH minus the queue occupancy is less than ROOM, and 0 otherwise.
- R9: Every flit granted on every input appears at the output exactly once, with the flits of each input kept in their original order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | NUM_IN | Per-input request; held until granted |
| inData | input | NUM_IN*DATA_W | Flit lanes, lane k at bits k*DATA_W upward |
| inGrant | output | NUM_IN | One-hot grant; the granted flit is taken on this edge |
| inOff | output | NUM_IN | "Off" level to each upstream sender |
| outValid | output | 1 | Queue head is valid |
| outData | output | DATA_W | Queue head flit |
| dnGrant | input | 1 | Downstream grants the head flit |
| dnOff | input | 1 | Downstream cannot accept |

## Verification
The bench targets saturation, with all three inputs requesting in every cycle. Here a pointer that failed to move past the winner would starve an input and break the two-cycle wait bound, and an off-by-one wrap would repeat or skip an index. It fills the queue behind a stalled consumer. A design that credited a same-cycle departure would grant while full, and a design that ignored `dnOff` would lose or duplicate flits, which the per-input sequence numbers expose. A single-input pattern with the other valids tied low, and random request and stall patterns, move the occupancy across the reserve threshold, so that an `inOff` level set one entry early or late is caught.

// File: rtl/gtsPkg.sv
package gtsPkg;

  // Strobes from the arbitration control to the queue datapath.
  typedef struct packed {
    logic push;
    logic pop;
  } gtsStrobeT;

  // Next index in a ring of n entries.
  function automatic int unsigned ringNext(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/gtsArbCtrl.sv
module gtsArbCtrl
  import gtsPkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int DEPTH  = 4,
  parameter int ROOM   = 2,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] inValid,
  input  logic              dnGrant,
  input  logic              dnOff,
  output logic [NUM_IN-1:0] inGrant,
  output logic [NUM_IN-1:0] inOff,
  output logic              outValid,
  output logic [IDX_W-1:0]  selIdx,
  output gtsStrobeT         strobes
);

  logic [CNT_W-1:0] occCount;
  logic [IDX_W-1:0] rrPtr;
  logic             notFull;
  logic             found;
  logic             offLevel;

  assign notFull  = (int'(occCount) != DEPTH);
  assign outValid = (occCount != '0);
  assign offLevel = ((DEPTH - int'(occCount)) < ROOM);
  assign inOff    = {NUM_IN{offLevel}};

  // Rotating search: first valid input starting at rrPtr.
  always_comb begin
    inGrant = '0;
    selIdx  = '0;
    found   = 1'b0;
    for (int k = 0; k < NUM_IN; k++) begin
      int cand;
      cand = int'(rrPtr) + k;
      if (cand >= NUM_IN) cand = cand - NUM_IN;
      if (!found && notFull && inValid[cand]) begin
        found         = 1'b1;
        inGrant[cand] = 1'b1;
        selIdx        = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    strobes.push = found;
    strobes.pop  = outValid && dnGrant && !dnOff;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occCount <= '0;
      rrPtr    <= '0;
    end else begin
      case ({strobes.push, strobes.pop})
        2'b10:   occCount <= occCount + 1'b1;
        2'b01:   occCount <= occCount - 1'b1;
        default: occCount <= occCount;
      endcase
      if (strobes.push) rrPtr <= IDX_W'(ringNext(int'(selIdx), NUM_IN));
    end
  end

endmodule

// File: rtl/gtsFifoPath.sv
module gtsFifoPath
  import gtsPkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN*DATA_W-1:0] inData,
  input  logic [IDX_W-1:0]         selIdx,
  input  gtsStrobeT                strobes,
  output logic [DATA_W-1:0]        outData
);

  logic [DATA_W-1:0] lane [NUM_IN];
  logic [DATA_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    assign lane[g] = inData[g*DATA_W +: DATA_W];
  end

  assign outData = slot[rdPtr];

  always_ff @(posedge clk) begin
    if (strobes.push) slot[wrPtr] <= lane[selIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.push) wrPtr <= PTR_W'(ringNext(int'(wrPtr), DEPTH));
      if (strobes.pop)  rdPtr <= PTR_W'(ringNext(int'(rdPtr), DEPTH));
    end
  end

endmodule

// File: rtl/gatherTopSwitch.sv
module gatherTopSwitch
  import gtsPkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int ROOM   = 2,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        inValid,
  input  logic [NUM_IN*DATA_W-1:0] inData,
  output logic [NUM_IN-1:0]        inGrant,
  output logic [NUM_IN-1:0]        inOff,
  output logic                     outValid,
  output logic [DATA_W-1:0]        outData,
  input  logic                     dnGrant,
  input  logic                     dnOff
);

  gtsStrobeT        strobes;
  logic [IDX_W-1:0] selIdx;

  gtsArbCtrl #(.NUM_IN(NUM_IN), .DEPTH(DEPTH), .ROOM(ROOM)) ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dnGrant(dnGrant), .dnOff(dnOff),
    .inGrant(inGrant), .inOff(inOff), .outValid(outValid),
    .selIdx(selIdx), .strobes(strobes)
  );

  gtsFifoPath #(.NUM_IN(NUM_IN), .DATA_W(DATA_W), .DEPTH(DEPTH)) path (
    .clk(clk), .rstN(rstN), .inData(inData), .selIdx(selIdx),
    .strobes(strobes), .outData(outData)
  );

endmodule

// File: rtl/gtsChk.sv
module gtsChk #(
  parameter int NUM_IN = 3,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int ROOM   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_IN-1:0] inValid,
  input logic [NUM_IN-1:0] inGrant,
  input logic [NUM_IN-1:0] inOff,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              dnGrant,
  input logic              dnOff
);

  int  shadowOcc;
  logic leaving;
  assign leaving = outValid && dnGrant && !dnOff;

  always_ff @(posedge clk) begin
    if (!rstN) shadowOcc <= 0;
    else shadowOcc <= shadowOcc + ((inGrant != '0) ? 1 : 0) - (leaving ? 1 : 0);
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rstN |=> !outValid);

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(inGrant));

  // R2
  grant_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inGrant & ~inValid) == '0);

  // R5
  head_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == (shadowOcc != 0));

  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !(dnGrant && !dnOff)) |=> (outValid && $stable(outData)));

  // R7
  full_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shadowOcc == DEPTH) |-> (inGrant == '0));

  // R8
  off_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    inOff == {NUM_IN{(DEPTH - shadowOcc) < ROOM}});

endmodule

bind gatherTopSwitch gtsChk #(.NUM_IN(NUM_IN), .DATA_W(DATA_W), .DEPTH(DEPTH), .ROOM(ROOM)) chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inGrant(inGrant), .inOff(inOff),
  .outValid(outValid), .outData(outData), .dnGrant(dnGrant), .dnOff(dnOff)
);

// File: tb/tb_gatherTopSwitch.sv
module tb_gatherTopSwitch;

  localparam int NIN   = 3;
  localparam int DW    = 8;
  localparam int DEPTH = 4;
  localparam int ROOM  = 2;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NIN-1:0]    inValid;
  logic [NIN*DW-1:0] inData;
  logic [NIN-1:0]    inGrant;
  logic [NIN-1:0]    inOff;
  logic              outValid;
  logic [DW-1:0]     outData;
  logic              dnGrant;
  logic              dnOff;

  always #5 clk = ~clk;

  gatherTopSwitch #(.NUM_IN(NIN), .DATA_W(DW), .DEPTH(DEPTH), .ROOM(ROOM)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inGrant(inGrant),
    .inOff(inOff), .outValid(outValid), .outData(outData), .dnGrant(dnGrant), .dnOff(dnOff)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state computed from the requirements.
  logic [DW-1:0] mq[$];
  int  mPtr;
  bit  pend  [NIN];
  int  seqTx [NIN];
  int  seqRx [NIN];
  int  waitN [NIN];
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit rnd(input int oneIn);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return (lfsr[7:0] % oneIn) == 0;
  endfunction

  // mode: 0 idle, 1 saturate, 2 saturate+stall, 3 input1 only, 4 random, 5 drain
  task automatic cycle(input int mode);
    logic [NIN-1:0] expGrant;
    bit full, popNow, anyGrant;
    int win;
    @(negedge clk);
    for (int i = 0; i < NIN; i++) begin
      if (!pend[i]) begin
        case (mode)
          1, 2: pend[i] = 1;
          3:    pend[i] = (i == 1);
          4:    pend[i] = rnd(2);
          default: pend[i] = 0;
        endcase
      end
      inValid[i] = pend[i];
      inData[i*DW +: DW] = {2'(i), 6'(seqTx[i])};
    end
    case (mode)
      2: begin dnGrant = rnd(4); dnOff = 1'b0; end
      4: begin dnGrant = rnd(2); dnOff = rnd(3); end
      default: begin dnGrant = 1'b1; dnOff = 1'b0; end
    endcase
    #1;
    full = (mq.size() == DEPTH);
    expGrant = '0;
    win = -1;
    if (!full) begin
      for (int k = 0; k < NIN; k++) begin
        int c = (mPtr + k) % NIN;
        if (win < 0 && pend[c]) begin win = c; expGrant[c] = 1'b1; end
      end
    end
    check(inGrant == expGrant, full ? "R7" : "R3", int'(inGrant), int'(expGrant));
    check(inOff == {NIN{(DEPTH - mq.size()) < ROOM}}, "R8", int'(inOff),
          ((DEPTH - mq.size()) < ROOM) ? 7 : 0);
    check(outValid == (mq.size() != 0), "R5", int'(outValid), int'(mq.size() != 0));
    if (mq.size() != 0) check(outData == mq[0], "R5", int'(outData), int'(mq[0]));
    anyGrant = (win >= 0);
    // fairness bookkeeping (R4)
    for (int i = 0; i < NIN; i++) begin
      if (i == win) begin
        check(waitN[i] <= 2, "R4", waitN[i], 2);
        waitN[i] = 0;
      end else if (pend[i] && anyGrant) waitN[i]++;
    end
    // model update
    popNow = (mq.size() != 0) && dnGrant && !dnOff;
    if (popNow) begin
      logic [DW-1:0] f = mq.pop_front();
      int src = int'(f[DW-1 -: 2]);
      if (src < NIN) begin
        check(int'(f[5:0]) == (seqRx[src] % 64), "R9", int'(f[5:0]), seqRx[src] % 64);
        seqRx[src]++;
      end else check(0, "R9", src, 0);
    end
    if (win >= 0) begin
      mq.push_back({2'(win), 6'(seqTx[win])});
      seqTx[win]++;
      pend[win] = 0;
      mPtr = (win + 1) % NIN;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = '0; inData = '0; dnGrant = 1'b0; dnOff = 1'b0;
    mPtr = 0;
    for (int i = 0; i < NIN; i++) begin pend[i] = 0; seqTx[i] = 0; seqRx[i] = 0; waitN[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1 reset state
    check(outValid == 1'b0, "R1", int'(outValid), 0);
    check(inOff == '0, "R1", int'(inOff), 0);
    check(inGrant == '0, "R1", int'(inGrant), 0);
    repeat (2)   cycle(0);
    repeat (60)  cycle(1);   // saturation, free flowing (R3 R4)
    repeat (200) cycle(2);   // saturation with stalled consumer (R6 R7 R8)
    repeat (40)  cycle(3);   // other inputs tied low (R2)
    repeat (800) cycle(4);   // random requests and stalls
    repeat (30)  cycle(5);   // drain
    // R9 end-to-end: nothing lost, nothing duplicated
    for (int i = 0; i < NIN; i++) check(seqRx[i] == seqTx[i], "R9", seqRx[i], seqTx[i]);
    check(outValid == 1'b0, "R9", int'(outValid), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule